// File: doc/BRIEF.md
# Variable Off-Time Peak Current Controller

This block is the digital control loop of a current-regulated buck converter. It drives one gate-enable output. During the on-phase it compares each sampled inductor-current word against a peak reference. The first sample that meets or exceeds that reference drops the gate on the next clock edge. The gate then stays low for an off-time measured in clock ticks, and after that the next on-phase begins. The switching period is therefore not fixed. It is set by how fast the current rises and by the off-time the loop chooses.

The first valid sample of each on-phase is kept as the valley current. The block takes the midpoint of the peak reference and this valley as its estimate of the cycle's average current. It compares that estimate with a mean-current reference. The signed error is scaled by a gain and added to the present off-time. The result is clamped between a floor and a ceiling and becomes the off-time for the following cycle. An average that is too high lengthens the off-time; an average that is too low shortens it.

A synchronous enable holds the gate low and reloads a preset off-time. That preset is used for the first cycle after enabling, when no valley has been measured yet.

Top module: `vot_pcmc_ctrl`

## Requirements
- R1: After reset with `en` low, `gate_on` and `upd_valid` are 0 and `toff_cur` equals `toff_init` from the first clock edge on.
- R2: In the on-phase, a clock edge that samples `sample_valid`=1 with `i_sense` >= `i_peak` makes `gate_on` 0 after that edge. Equality counts as a trip.
- R3: After a trip, `gate_on` stays 0 for exactly `toff_cur` clock cycles and then returns to 1. A value of 0 acts as 1.
- R4: `valley_q` takes the first valid sample of each on-phase. Later samples in the same on-phase leave it unchanged.
- R5: The off-time update is next = toff + floor(((floor((i_peak+valley)/2) − i_mean) × gain) / 2^KSHIFT), computed in signed arithmetic wide enough that nothing wraps.
- R6: A valley that puts the midpoint above `i_mean` makes the next off-phase longer than the previous one. A valley that puts it below makes the next off-phase shorter.
- R7: In the first on-phase after `en` rises, the valley is captured but the off-time is not updated. The first off-phase lasts `toff_init` cycles.
- R8: An updated off-time is never below `toff_min`.
- R9: An updated off-time is never above `toff_max`. If the two bounds conflict, `toff_min` wins.
- R10: Samples presented while the gate is low are ignored. They neither trip nor change `valley_q`, and the off-phase length is unaffected.
- R11: `upd_valid` is a one-cycle pulse in the cycle after the valley capture that updated the off-time. `toff_cur` shows the new value in that same cycle and changes at no other time while enabled.
- R12: While `en` is low, `gate_on` is 0 after the next edge and `toff_cur` follows `toff_init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous run enable |
| sample_valid | input | 1 | `i_sense` holds a fresh current sample |
| i_sense | input | IW | Sampled inductor current |
| i_peak | input | IW | Peak-current reference |
| i_mean | input | IW | Mean-current reference |
| gain | input | KW | Loop gain, fixed point with KSHIFT fraction bits |
| toff_init | input | TW | Off-time preset used after enabling |
| toff_min | input | TW | Off-time floor |
| toff_max | input | TW | Off-time ceiling |
| gate_on | output | 1 | Gate enable for the power switch |
| upd_valid | output | 1 | One-cycle strobe on an off-time update |
| toff_cur | output | TW | Off-time in effect, in clock cycles |
| valley_q | output | IW | Latched valley current of the current cycle |

## Verification
The hardest situation to reach from the ports is an update that lands exactly on a clamp boundary or on a floor-rounded negative step. The valley is whatever the bench drives at the first sample of an on-phase, so the stimulus steers the off-time by choosing each cycle's valley. Chosen valleys first walk it down to the floor. Two rising steps then land it exactly on the ceiling, and a third overshoots it. The gain is then changed so that a zero error holds the off-time steady and a negative step has a non-integer quotient. During every off-phase the bench keeps presenting over-peak samples, to show that they have no effect.

// File: rtl/vot_pcmc_pkg.sv
package vot_pcmc_pkg;
    typedef enum logic [1:0] {
        ST_DIS = 2'd0,
        ST_ON  = 2'd1,
        ST_OFF = 2'd2
    } vot_state_e;
endpackage

// File: rtl/vot_peak_cmp.sv
module vot_peak_cmp #(
    parameter int IW = 12
) (
    input  logic          valid,
    input  logic [IW-1:0] sense,
    input  logic [IW-1:0] peak,
    output logic          trip
);
    always_comb begin
        trip = valid && (sense >= peak);
    end
endmodule

// File: rtl/vot_toff_update.sv
module vot_toff_update #(
    parameter int IW     = 12,
    parameter int TW     = 16,
    parameter int KW     = 8,
    parameter int KSHIFT = 4
) (
    input  logic [TW-1:0] toff_prev,
    input  logic [IW-1:0] valley,
    input  logic [IW-1:0] peak,
    input  logic [IW-1:0] mean,
    input  logic [KW-1:0] gain,
    input  logic [TW-1:0] toff_min,
    input  logic [TW-1:0] toff_max,
    output logic [TW-1:0] toff_next
);
    localparam int AW = IW + 2;
    localparam int PW = AW + KW + 1;
    localparam int SW = ((PW > TW) ? PW : TW) + 2;

    logic [IW:0]            mid_sum;
    logic [IW-1:0]          mid;
    logic signed [AW-1:0]   err;
    logic signed [PW-1:0]   err_x;
    logic signed [PW-1:0]   gain_x;
    logic signed [PW-1:0]   prod;
    logic signed [PW-1:0]   step;
    logic signed [SW-1:0]   cand;
    logic signed [SW-1:0]   lim_hi;
    logic signed [SW-1:0]   lim_lo;
    logic signed [SW-1:0]   clamped;

    always_comb begin
        mid_sum = {1'b0, peak} + {1'b0, valley};
        mid     = IW'(mid_sum >> 1);
        err     = $signed({2'b00, mid}) - $signed({2'b00, mean});
        err_x   = PW'(err);
        gain_x  = $signed(PW'({1'b0, gain}));
        prod    = err_x * gain_x;
        step    = prod >>> KSHIFT;
        cand    = SW'(step) + $signed(SW'({1'b0, toff_prev}));
        lim_hi  = $signed(SW'({1'b0, toff_max}));
        lim_lo  = $signed(SW'({1'b0, toff_min}));
        clamped = (cand > lim_hi) ? lim_hi : cand;
        clamped = (clamped < lim_lo) ? lim_lo : clamped;
        toff_next = TW'(clamped);
    end
endmodule

// File: rtl/vot_pcmc_ctrl.sv
module vot_pcmc_ctrl
    import vot_pcmc_pkg::*;
#(
    parameter int IW     = 12,
    parameter int TW     = 16,
    parameter int KW     = 8,
    parameter int KSHIFT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          sample_valid,
    input  logic [IW-1:0] i_sense,
    input  logic [IW-1:0] i_peak,
    input  logic [IW-1:0] i_mean,
    input  logic [KW-1:0] gain,
    input  logic [TW-1:0] toff_init,
    input  logic [TW-1:0] toff_min,
    input  logic [TW-1:0] toff_max,
    output logic          gate_on,
    output logic          upd_valid,
    output logic [TW-1:0] toff_cur,
    output logic [IW-1:0] valley_q
);
    localparam int CW = TW + 1;

    typedef struct packed {
        vot_state_e    st;
        logic          gate;
        logic          upd;
        logic          need_valley;
        logic          skip_upd;
        logic [TW-1:0] cnt;
        logic [TW-1:0] toff;
        logic [IW-1:0] valley;
    } ctl_t;

    ctl_t          q, d;
    logic          trip;
    logic [TW-1:0] toff_new;
    logic          off_done;

    vot_peak_cmp #(.IW(IW)) u_cmp (
        .valid (sample_valid),
        .sense (i_sense),
        .peak  (i_peak),
        .trip  (trip)
    );

    vot_toff_update #(.IW(IW), .TW(TW), .KW(KW), .KSHIFT(KSHIFT)) u_upd (
        .toff_prev (q.toff),
        .valley    (i_sense),
        .peak      (i_peak),
        .mean      (i_mean),
        .gain      (gain),
        .toff_min  (toff_min),
        .toff_max  (toff_max),
        .toff_next (toff_new)
    );

    always_comb begin
        off_done = (CW'(q.cnt) + CW'(1)) >= CW'(q.toff);
    end

    always_comb begin
        d     = q;
        d.upd = 1'b0;
        if (!en) begin
            d.st          = ST_DIS;
            d.gate        = 1'b0;
            d.cnt         = '0;
            d.toff        = toff_init;
            d.need_valley = 1'b0;
            d.skip_upd    = 1'b1;
        end else begin
            unique case (q.st)
                ST_DIS: begin
                    d.st          = ST_ON;
                    d.gate        = 1'b1;
                    d.need_valley = 1'b1;
                    d.skip_upd    = 1'b1;
                end
                ST_ON: begin
                    if (sample_valid && q.need_valley) begin
                        d.valley      = i_sense;
                        d.need_valley = 1'b0;
                        d.skip_upd    = 1'b0;
                        if (!q.skip_upd) begin
                            d.toff = toff_new;
                            d.upd  = 1'b1;
                        end
                    end
                    if (trip) begin
                        d.st   = ST_OFF;
                        d.gate = 1'b0;
                        d.cnt  = '0;
                    end
                end
                ST_OFF: begin
                    if (off_done) begin
                        d.st          = ST_ON;
                        d.gate        = 1'b1;
                        d.need_valley = 1'b1;
                    end else begin
                        d.cnt = q.cnt + TW'(1);
                    end
                end
                default: begin
                    d.st   = ST_DIS;
                    d.gate = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign gate_on   = q.gate;
    assign upd_valid = q.upd;
    assign toff_cur  = q.toff;
    assign valley_q  = q.valley;
endmodule

// File: rtl/vot_pcmc_chk.sv
module vot_pcmc_chk #(
    parameter int IW = 12,
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          sample_valid,
    input logic [IW-1:0] i_sense,
    input logic [IW-1:0] i_peak,
    input logic [TW-1:0] toff_init,
    input logic [TW-1:0] toff_min,
    input logic [TW-1:0] toff_max,
    input logic          gate_on,
    input logic          upd_valid,
    input logic [TW-1:0] toff_cur,
    input logic [IW-1:0] valley_q
);
    logic [TW:0] low_len;
    logic        had_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_len <= '0;
            had_on  <= 1'b0;
        end else begin
            low_len <= (!en || gate_on) ? '0 : low_len + (TW+1)'(1);
            had_on  <= en && (had_on || gate_on);
        end
    end

    AST_DISABLE_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !gate_on); // R12
    AST_DISABLE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> toff_cur == $past(toff_init)); // R12
    AST_TRIP_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        gate_on && sample_valid && (i_sense >= i_peak) |=> !gate_on); // R2
    AST_OFF_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        en && gate_on && had_on && low_len != '0 && toff_cur != '0
        |-> low_len == (TW+1)'(toff_cur)); // R3
    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> toff_cur >= toff_min); // R8
    AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && (toff_min <= toff_max) |-> toff_cur <= toff_max); // R9
    AST_OFF_VALLEY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_on |=> $stable(valley_q)); // R10
    AST_UPD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> !upd_valid); // R11
    AST_TOFF_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(en) && !upd_valid |-> $stable(toff_cur)); // R11
endmodule

bind vot_pcmc_ctrl vot_pcmc_chk #(.IW(IW), .TW(TW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .sample_valid (sample_valid),
    .i_sense      (i_sense),
    .i_peak       (i_peak),
    .toff_init    (toff_init),
    .toff_min     (toff_min),
    .toff_max     (toff_max),
    .gate_on      (gate_on),
    .upd_valid    (upd_valid),
    .toff_cur     (toff_cur),
    .valley_q     (valley_q)
);

// File: tb/tb_vot_pcmc_ctrl.sv
module tb_vot_pcmc_ctrl;
    localparam int IW = 12;
    localparam int TW = 16;
    localparam int KW = 8;
    localparam int KSHIFT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          sample_valid = 1'b0;
    logic [IW-1:0] i_sense = '0;
    logic [IW-1:0] i_peak = 12'd2000;
    logic [IW-1:0] i_mean = 12'd1900;
    logic [KW-1:0] gain = 8'd16;
    logic [TW-1:0] toff_init = 16'd40;
    logic [TW-1:0] toff_min = 16'd10;
    logic [TW-1:0] toff_max = 16'd200;
    logic          gate_on;
    logic          upd_valid;
    logic [TW-1:0] toff_cur;
    logic [IW-1:0] valley_q;

    int checks = 0;
    int fails = 0;
    int model_toff = 40;
    int last_len = 0;
    int exp_q[$];
    bit prev_upd = 1'b0;
    bit done = 1'b0;
    int popped;

    always #5 clk = ~clk;

    vot_pcmc_ctrl #(.IW(IW), .TW(TW), .KW(KW), .KSHIFT(KSHIFT)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .sample_valid(sample_valid),
        .i_sense(i_sense), .i_peak(i_peak), .i_mean(i_mean), .gain(gain),
        .toff_init(toff_init), .toff_min(toff_min), .toff_max(toff_max),
        .gate_on(gate_on), .upd_valid(upd_valid), .toff_cur(toff_cur),
        .valley_q(valley_q)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_toff(input int prev, input int valley);
        int mid, err, step, n;
        mid  = (int'(i_peak) + valley) / 2;
        err  = mid - int'(i_mean);
        step = (err * int'(gain)) >>> KSHIFT;
        n    = prev + step;
        if (n > int'(toff_max)) n = int'(toff_max);
        if (n < int'(toff_min)) n = int'(toff_min);
        return n;
    endfunction

    // Monitor: pops expected off-time values on every update strobe
    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11 unexpected update", int'(toff_cur), -1);
                end else begin
                    popped = exp_q.pop_front();
                    check(int'(toff_cur) == popped, "R5 updated off-time", int'(toff_cur), popped);
                end
                check(!prev_upd, "R11 strobe longer than one cycle", 1, 0);
            end
            prev_upd = upd_valid;
        end
    end

    // Driver: called at a falling edge with gate_on already high
    task automatic on_phase(input int valley, input bit upd, input int over, output int len);
        sample_valid = 1'b1;
        i_sense = IW'(valley);
        if (upd) begin
            model_toff = next_toff(model_toff, valley);
            exp_q.push_back(model_toff);
        end
        @(negedge clk);
        i_sense = IW'(valley - 20);
        @(negedge clk);
        check(int'(valley_q) == valley, "R4 valley is first sample", int'(valley_q), valley);
        i_sense = IW'(int'(i_peak) + over);
        @(negedge clk);
        check(!gate_on, "R2 trip drops gate", int'(gate_on), 0);
        i_sense = '1;
        len = 1;
        for (int g = 0; g < 1000; g++) begin
            @(negedge clk);
            if (gate_on) break;
            len++;
        end
        check(len == model_toff, "R3 off-phase length", len, model_toff);
        check(int'(valley_q) == valley, "R10 off-phase samples ignored", int'(valley_q), valley);
        check(exp_q.size() == 0, "R11 update strobe seen", exp_q.size(), 0);
    endtask

    initial begin
        int len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!gate_on, "R1 gate low after reset", int'(gate_on), 0);
        check(!upd_valid, "R1 no strobe after reset", int'(upd_valid), 0);
        check(toff_cur == toff_init, "R1 off-time preset", int'(toff_cur), int'(toff_init));

        en = 1'b1;
        @(negedge clk);
        check(gate_on, "R7 gate rises on enable", int'(gate_on), 1);
        model_toff = int'(toff_init);
        on_phase(1700, 1'b0, 0, len);
        check(len == 40, "R7 first off-phase uses preset", len, 40);
        last_len = len;

        on_phase(1900, 1'b1, 3, len);
        check(len > last_len, "R6 high average lengthens", len, last_len + 1);
        last_len = len;
        on_phase(1700, 1'b1, 0, len);
        check(len < last_len, "R6 low average shortens", len, last_len - 1);

        on_phase(1000, 1'b1, 0, len);
        check(len == 10, "R8 floor clamp", len, 10);
        on_phase(1990, 1'b1, 0, len);
        check(len == 105, "R5 step from floor", len, 105);
        on_phase(1990, 1'b1, 0, len);
        check(len == 200, "R9 lands on ceiling", len, 200);
        on_phase(1990, 1'b1, 0, len);
        check(len == 200, "R9 ceiling clamp", len, 200);

        gain = 8'd5;
        on_phase(1801, 1'b1, 0, len);
        check(len == 200, "R5 truncated midpoint zero error", len, 200);
        on_phase(1700, 1'b1, 0, len);
        check(len == 184, "R5 negative step floors", len, 184);

        en = 1'b0;
        @(negedge clk);
        check(!gate_on, "R12 disable drops gate", int'(gate_on), 0);
        check(toff_cur == 16'd40, "R12 reload preset", int'(toff_cur), 40);
        toff_init = 16'd25;
        @(negedge clk);
        @(negedge clk);
        check(toff_cur == 16'd25, "R12 follows preset", int'(toff_cur), 25);
        en = 1'b1;
        @(negedge clk);
        model_toff = 25;
        on_phase(1200, 1'b0, 0, len);
        check(len == 25, "R7 preset after re-enable", len, 25);

        toff_min = 16'd30;
        toff_max = 16'd20;
        on_phase(1900, 1'b1, 0, len);
        check(len == 30, "R9 floor wins over ceiling", len, 30);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog R3 run hung", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule